// File: doc/BRIEF.md
# AXI Transfer History Monitor

This block terminates the read-address, write-address and write-data channels of an AXI4 slave port and keeps a short history of what the host sent on each of them. It accepts transfers using only the state of its own response channels. It never looks at an address, data word or control field to decide anything. Read bursts are answered with a constant data word and write bursts with an OKAY write response, so a host can exercise the port without any real slave behind it.

Each of the three channels feeds its own circular history of eight records, and older records are overwritten. A combinational lookup port takes a channel code and a slot number and returns the matching record. Slot 0 is the newest record. A saturating count is also provided for each channel. A display engine can scan channel 0..2 × slot 0..7 to draw the full 3-by-8 table. A synchronous clear empties all three histories.

On the response side, r_valid and b_valid follow valid/ready rules. Once raised, each is held with stable payload until the host asserts ready. While a read burst is being returned, ar_ready is low. While a write response waits, aw_ready and w_ready are low. This is the only back-pressure the block applies.

Top module: `axi_txn_history`

## Requirements
- R1: A record is written into a channel's history only on a cycle where that channel's valid and ready are both high. Address records pack {id, size[2:0], len[7:0], addr} with addr in the low bits. Write-data records pack {last, strb, data} with data in the low bits. Records are zero-extended to the rd_record width.
- R2: Each history keeps the last 8 accepted records. For slot k, the lookup returns the record accepted k transfers before the newest, so slot 0 is the newest.
- R3: cnt_ar, cnt_aw and cnt_w each rise by one per capture and saturate at 8. All three are 0 after reset.
- R4: The three histories are independent, and a capture on one channel leaves the other two counts and contents unchanged.
- R5: w_ready and aw_ready are high whenever no write response is pending, and low while one is. ar_ready is high whenever no read burst is being returned. No payload field affects any ready.
- R6: b_valid rises in the cycle after the edge that accepts a write beat with w_last=1, never earlier. b_resp is OKAY (2'b00) and b_id is the most recently accepted write-address ID. b_valid and b_id stay stable until b_ready.
- R7: An accepted read address with length L produces L+1 beats. Each beat has r_data = RD_FILL (default 64'hA5A5_5A5A_0F0F_F0F0), r_resp = OKAY and r_id equal to the request ID. r_last is high on the final beat only. r_valid holds while r_ready is low.
- R8: A clear pulse zeroes all three counts at the next edge. A transfer accepted in the same cycle as clear is acknowledged but not recorded.
- R9: rd_chan selects the history: 0 is read address, 1 is write address, 2 is write data. When rd_slot is not below the selected count, or rd_chan is 3, rd_hit is 0 and rd_record is all zeros.
- R10: Three single-beat read-write-read sequences, with sizes of 8, 4 and 1 bytes, leave counts of 6 read-address, 3 write-address and 3 write-data records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empties all histories |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read address |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size code |
| ar_id | input | ID_W | Read ID |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | DATA_W | Constant read data |
| r_resp | output | 2 | Read response, always OKAY |
| r_last | output | 1 | Final read beat |
| r_id | output | ID_W | Read data ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write address |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size code |
| aw_id | input | ID_W | Write ID |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Final write beat |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response, always OKAY |
| b_id | output | ID_W | Write response ID |
| rd_chan | input | 2 | Lookup channel select |
| rd_slot | input | 3 | Lookup slot, 0 = newest |
| rd_hit | output | 1 | Looked-up slot holds a record |
| rd_record | output | DATA_W+DATA_W/8+1 | Looked-up record |
| cnt_ar | output | 4 | Read-address records held |
| cnt_aw | output | 4 | Write-address records held |
| cnt_w | output | 4 | Write-data records held |

## Verification
The capture path is driven with a mixed-size read-write-read sequence, which shows that each channel counts only its own handshakes. A ten-transfer run on one channel shows that slot ordering stays correct after the ring pointer wraps. A three-record partial fill shows that empty slots read back as misses. Payload held with valid low, and a write beat offered while a response is stalled, show that the block captures on the handshake and not on valid. A clear raised together with a transfer shows which of the two wins. The stalled write response and a stalled four-beat read show that response timing and payload stay stable under back-pressure.

// File: rtl/axi_hist_pkg.sv
package axi_hist_pkg;

  typedef enum logic [1:0] {
    CH_RADDR = 2'd0,
    CH_WADDR = 2'd1,
    CH_WDATA = 2'd2,
    CH_NONE  = 2'd3
  } hist_chan_e;

  localparam int NUM_CH = 3;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
  localparam int RESP_W = 2;

  localparam logic [RESP_W-1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/hist_ring.sv
// Circular record history: newest-first lookup, saturating fill count.
// DEPTH must be a power of two so the pointer wraps by plain overflow.
module hist_ring #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic [PTR_W-1:0] slot,
  output logic [WIDTH-1:0] dout,
  output logic             hit,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= wr_ptr + PTR_W'(1);
      if (count != CNT_W'(DEPTH)) count <= count + CNT_W'(1);
    end
  end

  // Storage carries no reset; unread slots are masked by the count.
  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= din;
  end

  assign rd_idx = wr_ptr - PTR_W'(1) - slot;
  assign hit    = (CNT_W'(slot) < count);
  assign dout   = hit ? mem[rd_idx] : '0;

endmodule

// File: rtl/axi_min_responder.sv
// Minimal AXI slave responses: constant read bursts, OKAY write responses.
module axi_min_responder
  import axi_hist_pkg::*;
#(
  parameter int                ID_W    = 4,
  parameter int                DATA_W  = 64,
  parameter logic [DATA_W-1:0] RD_FILL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [ID_W-1:0]   ar_id,
  output logic              ar_ready,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic [RESP_W-1:0] r_resp,
  output logic              r_last,
  output logic [ID_W-1:0]   r_id,
  input  logic              aw_valid,
  input  logic [ID_W-1:0]   aw_id,
  output logic              aw_ready,
  input  logic              w_valid,
  input  logic              w_last,
  output logic              w_ready,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [RESP_W-1:0] b_resp,
  output logic [ID_W-1:0]   b_id
);

  // Read side: one burst in flight, beats counted down to zero.
  logic             rd_busy;
  logic [LEN_W-1:0] rd_left;
  logic [ID_W-1:0]  rd_id_q;

  assign ar_ready = !rd_busy;
  assign r_valid  = rd_busy;
  assign r_last   = rd_busy && (rd_left == '0);
  assign r_data   = RD_FILL;
  assign r_resp   = RESP_OKAY;
  assign r_id     = rd_id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_left <= '0;
      rd_id_q <= '0;
    end else if (ar_valid && ar_ready) begin
      rd_busy <= 1'b1;
      rd_left <= ar_len;
      rd_id_q <= ar_id;
    end else if (r_valid && r_ready) begin
      if (rd_left == '0) rd_busy <= 1'b0;
      else               rd_left <= rd_left - LEN_W'(1);
    end
  end

  // Write side: stall address and data while a response waits.
  logic            b_pend;
  logic [ID_W-1:0] b_id_q;
  logic [ID_W-1:0] aw_id_q;

  assign aw_ready = !b_pend;
  assign w_ready  = !b_pend;
  assign b_valid  = b_pend;
  assign b_resp   = RESP_OKAY;
  assign b_id     = b_id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_pend  <= 1'b0;
      b_id_q  <= '0;
      aw_id_q <= '0;
    end else begin
      if (aw_valid && aw_ready) aw_id_q <= aw_id;
      if (w_valid && w_ready && w_last) begin
        b_pend <= 1'b1;
        b_id_q <= (aw_valid && aw_ready) ? aw_id : aw_id_q;
      end else if (b_pend && b_ready) begin
        b_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/axi_txn_history.sv
// AXI slave-side transfer monitor with per-channel capture histories.
module axi_txn_history
  import axi_hist_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                DATA_W  = 64,
  parameter int                ID_W    = 4,
  parameter int                DEPTH   = 8,
  parameter logic [DATA_W-1:0] RD_FILL = 64'hA5A5_5A5A_0F0F_F0F0,
  localparam int STRB_W = DATA_W / 8,
  localparam int AREC_W = ID_W + SIZE_W + LEN_W + ADDR_W,
  localparam int WREC_W = 1 + STRB_W + DATA_W,
  localparam int REC_W  = (WREC_W > AREC_W) ? WREC_W : AREC_W,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic [ID_W-1:0]   ar_id,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [DATA_W-1:0] r_data,
  output logic [RESP_W-1:0] r_resp,
  output logic              r_last,
  output logic [ID_W-1:0]   r_id,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [RESP_W-1:0] b_resp,
  output logic [ID_W-1:0]   b_id,
  input  logic [1:0]        rd_chan,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic              rd_hit,
  output logic [REC_W-1:0]  rd_record,
  output logic [CNT_W-1:0]  cnt_ar,
  output logic [CNT_W-1:0]  cnt_aw,
  output logic [CNT_W-1:0]  cnt_w
);

  axi_min_responder #(
    .ID_W   (ID_W),
    .DATA_W (DATA_W),
    .RD_FILL(RD_FILL)
  ) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ar_valid(ar_valid),
    .ar_len  (ar_len),
    .ar_id   (ar_id),
    .ar_ready(ar_ready),
    .r_valid (r_valid),
    .r_ready (r_ready),
    .r_data  (r_data),
    .r_resp  (r_resp),
    .r_last  (r_last),
    .r_id    (r_id),
    .aw_valid(aw_valid),
    .aw_id   (aw_id),
    .aw_ready(aw_ready),
    .w_valid (w_valid),
    .w_last  (w_last),
    .w_ready (w_ready),
    .b_valid (b_valid),
    .b_ready (b_ready),
    .b_resp  (b_resp),
    .b_id    (b_id)
  );

  logic [NUM_CH-1:0][REC_W-1:0] rec_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
  logic [NUM_CH-1:0]            hit_v;

  // One ring per channel; each ring is only as wide as its own record.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int RW = (c == int'(CH_WDATA)) ? WREC_W : AREC_W;
    logic [RW-1:0] rin;
    logic [RW-1:0] rout;
    logic          psh;

    if (c == int'(CH_WDATA)) begin : g_wdata
      assign rin = {w_last, w_strb, w_data};
      assign psh = w_valid && w_ready;
    end else if (c == int'(CH_WADDR)) begin : g_waddr
      assign rin = {aw_id, aw_size, aw_len, aw_addr};
      assign psh = aw_valid && aw_ready;
    end else begin : g_raddr
      assign rin = {ar_id, ar_size, ar_len, ar_addr};
      assign psh = ar_valid && ar_ready;
    end

    hist_ring #(
      .WIDTH(RW),
      .DEPTH(DEPTH)
    ) u_ring (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(clear),
      .push (psh),
      .din  (rin),
      .slot (rd_slot),
      .dout (rout),
      .hit  (hit_v[c]),
      .count(cnt_v[c])
    );

    assign rec_v[c] = REC_W'(rout);
  end

  always_comb begin
    rd_hit    = 1'b0;
    rd_record = '0;
    case (rd_chan)
      CH_RADDR: begin rd_hit = hit_v[0]; rd_record = rec_v[0]; end
      CH_WADDR: begin rd_hit = hit_v[1]; rd_record = rec_v[1]; end
      CH_WDATA: begin rd_hit = hit_v[2]; rd_record = rec_v[2]; end
      default:  begin rd_hit = 1'b0;     rd_record = '0;       end
    endcase
  end

  assign cnt_ar = cnt_v[0];
  assign cnt_aw = cnt_v[1];
  assign cnt_w  = cnt_v[2];

endmodule

// File: rtl/axi_txn_history_chk.sv
module axi_txn_history_chk #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic             w_valid,
  input logic             w_ready,
  input logic             w_last,
  input logic             b_valid,
  input logic             b_ready,
  input logic [ID_W-1:0]  b_id,
  input logic             r_valid,
  input logic             r_ready,
  input logic             r_last,
  input logic [1:0]       rd_chan,
  input logic [PTR_W-1:0] rd_slot,
  input logic             rd_hit,
  input logic [CNT_W-1:0] cnt_ar,
  input logic [CNT_W-1:0] cnt_aw,
  input logic [CNT_W-1:0] cnt_w
);

  a_r3_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ar <= CNT_W'(DEPTH)) && (cnt_aw <= CNT_W'(DEPTH)) && (cnt_w <= CNT_W'(DEPTH)));

  a_r3_ar_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && ar_valid && ar_ready && cnt_ar != CNT_W'(DEPTH))
    |=> cnt_ar == $past(cnt_ar) + CNT_W'(1));

  a_r1_aw_no_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(aw_valid && aw_ready)) |=> $stable(cnt_aw));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_ar == '0) && (cnt_aw == '0) && (cnt_w == '0));

  a_r5_write_open: assert property (@(posedge clk) disable iff (!rst_n)
    !b_valid |-> (w_ready && aw_ready));

  a_r6_b_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready && w_last) |=> b_valid);

  a_r6_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    r_last |-> r_valid);

  a_r7_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> r_valid);

  a_r9_hit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_chan == 2'd0) |-> (CNT_W'(rd_slot) < cnt_ar));

  a_r9_no_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan == 2'd3) |-> !rd_hit);

endmodule

bind axi_txn_history axi_txn_history_chk #(
  .ID_W (ID_W),
  .DEPTH(DEPTH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear   (clear),
  .ar_valid(ar_valid),
  .ar_ready(ar_ready),
  .aw_valid(aw_valid),
  .aw_ready(aw_ready),
  .w_valid (w_valid),
  .w_ready (w_ready),
  .w_last  (w_last),
  .b_valid (b_valid),
  .b_ready (b_ready),
  .b_id    (b_id),
  .r_valid (r_valid),
  .r_ready (r_ready),
  .r_last  (r_last),
  .rd_chan (rd_chan),
  .rd_slot (rd_slot),
  .rd_hit  (rd_hit),
  .cnt_ar  (cnt_ar),
  .cnt_aw  (cnt_aw),
  .cnt_w   (cnt_w)
);

// File: tb/axi_txn_history_tb.sv
`timescale 1ns/1ps
module axi_txn_history_tb;

  localparam logic [63:0] FILL = 64'hA5A5_5A5A_0F0F_F0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        ar_valid = 1'b0, aw_valid = 1'b0, w_valid = 1'b0;
  logic [31:0] ar_addr = '0, aw_addr = '0;
  logic [7:0]  ar_len = '0, aw_len = '0;
  logic [2:0]  ar_size = '0, aw_size = '0;
  logic [3:0]  ar_id = '0, aw_id = '0;
  logic [63:0] w_data = '0;
  logic [7:0]  w_strb = '0;
  logic        w_last = 1'b0;
  logic        r_ready = 1'b1, b_ready = 1'b1;
  logic [1:0]  rd_chan = '0;
  logic [2:0]  rd_slot = '0;
  logic        ar_ready, aw_ready, w_ready, r_valid, r_last, b_valid, rd_hit;
  logic [63:0] r_data;
  logic [1:0]  r_resp, b_resp;
  logic [3:0]  r_id, b_id, cnt_ar, cnt_aw, cnt_w;
  logic [72:0] rd_record;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  axi_txn_history u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_id(ar_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .r_last(r_last), .r_id(r_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_id(aw_id),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp), .b_id(b_id),
    .rd_chan(rd_chan), .rd_slot(rd_slot), .rd_hit(rd_hit), .rd_record(rd_record),
    .cnt_ar(cnt_ar), .cnt_aw(cnt_aw), .cnt_w(cnt_w)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [72:0] arec(input logic [31:0] a, input logic [7:0] l,
                                       input logic [2:0] s, input logic [3:0] id);
    return 73'({id, s, l, a});
  endfunction

  function automatic logic [72:0] wrec(input logic [63:0] d, input logic [7:0] st,
                                       input logic lst);
    return {lst, st, d};
  endfunction

  task automatic peek(input logic [1:0] ch, input logic [2:0] sl,
                      output logic hit, output logic [72:0] rec);
    @(negedge clk);
    rd_chan = ch; rd_slot = sl;
    #1;
    hit = rd_hit; rec = rd_record;
  endtask

  task automatic do_ar(input logic [31:0] a, input logic [7:0] l,
                       input logic [2:0] s, input logic [3:0] id);
    @(negedge clk);
    ar_addr = a; ar_len = l; ar_size = s; ar_id = id; ar_valid = 1'b1;
    while (!ar_ready) @(negedge clk);
    @(posedge clk); #1;
    ar_valid = 1'b0;
  endtask

  task automatic do_aw(input logic [31:0] a, input logic [7:0] l,
                       input logic [2:0] s, input logic [3:0] id);
    @(negedge clk);
    aw_addr = a; aw_len = l; aw_size = s; aw_id = id; aw_valid = 1'b1;
    while (!aw_ready) @(negedge clk);
    @(posedge clk); #1;
    aw_valid = 1'b0;
  endtask

  task automatic do_w(input logic [63:0] d, input logic [7:0] st, input logic lst);
    @(negedge clk);
    w_data = d; w_strb = st; w_last = lst; w_valid = 1'b1;
    while (!w_ready) @(negedge clk);
    @(posedge clk); #1;
    w_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic h; logic [72:0] r;
    @(negedge clk);
    check("R3", "cnt_ar after reset", 128'(cnt_ar), 128'd0);
    check("R3", "cnt_aw after reset", 128'(cnt_aw), 128'd0);
    check("R3", "cnt_w after reset",  128'(cnt_w),  128'd0);
    check("R5", "readies after reset", 128'({ar_ready, aw_ready, w_ready}), 128'h7);
    check("R6", "b_valid after reset", 128'(b_valid), 128'd0);
    check("R7", "r_valid after reset", 128'(r_valid), 128'd0);
    peek(2'd0, 3'd0, h, r);
    check("R9", "hit on empty history", 128'(h), 128'd0);
  endtask

  // R10: mixed-size read-write-read sequence
  task automatic t_rwr_sizes();
    logic h; logic [72:0] r;
    pulse_clear();
    do_ar(32'h0000_0008, 8'd0, 3'd3, 4'd1);
    do_aw(32'h0000_0008, 8'd0, 3'd3, 4'd1);
    do_w(64'h0123_4567_89AB_CDEF, 8'hFF, 1'b1);
    do_ar(32'h0000_0008, 8'd0, 3'd3, 4'd1);
    do_ar(32'h0000_0004, 8'd0, 3'd2, 4'd2);
    do_aw(32'h0000_0004, 8'd0, 3'd2, 4'd2);
    do_w(64'h0000_0000_1234_5678, 8'h0F, 1'b1);
    do_ar(32'h0000_0004, 8'd0, 3'd2, 4'd2);
    do_ar(32'h0000_0001, 8'd0, 3'd0, 4'd3);
    do_aw(32'h0000_0001, 8'd0, 3'd0, 4'd3);
    do_w(64'h0000_0000_0000_0012, 8'h01, 1'b1);
    do_ar(32'h0000_0001, 8'd0, 3'd0, 4'd3);
    wait_idle();
    check("R10", "read-address records", 128'(cnt_ar), 128'd6);
    check("R10", "write-address records", 128'(cnt_aw), 128'd3);
    check("R10", "write-data records", 128'(cnt_w), 128'd3);
    peek(2'd0, 3'd0, h, r);
    check("R1", "newest read-address record", 128'(r), 128'(arec(32'h1, 8'd0, 3'd0, 4'd3)));
    peek(2'd0, 3'd5, h, r);
    check("R2", "oldest read-address record", 128'(r), 128'(arec(32'h8, 8'd0, 3'd3, 4'd1)));
    peek(2'd2, 3'd0, h, r);
    check("R1", "newest write-data record", 128'(r), 128'(wrec(64'h12, 8'h01, 1'b1)));
    peek(2'd2, 3'd2, h, r);
    check("R2", "oldest write-data record", 128'(r),
          128'(wrec(64'h0123_4567_89AB_CDEF, 8'hFF, 1'b1)));
    peek(2'd1, 3'd1, h, r);
    check("R1", "middle write-address record", 128'(r), 128'(arec(32'h4, 8'd0, 3'd2, 4'd2)));
  endtask

  // R2/R3/R4: wrap past eight entries on one channel
  task automatic t_wrap();
    logic h; logic [72:0] r;
    pulse_clear();
    for (int i = 0; i < 10; i++)
      do_aw(32'h100 + 32'(i), 8'(i), 3'd2, 4'(i));
    @(negedge clk);
    check("R3", "count saturates at 8", 128'(cnt_aw), 128'd8);
    check("R4", "read-address count untouched", 128'(cnt_ar), 128'd0);
    check("R4", "write-data count untouched", 128'(cnt_w), 128'd0);
    for (int k = 0; k < 8; k++) begin
      peek(2'd1, 3'(k), h, r);
      check("R2", $sformatf("wrapped slot %0d", k), 128'(r),
            128'(arec(32'h100 + 32'(9 - k), 8'(9 - k), 3'd2, 4'(9 - k))));
    end
  endtask

  // R9: partial fill and unused channel code
  task automatic t_partial();
    logic h; logic [72:0] r;
    pulse_clear();
    do_w(64'hAAAA, 8'h03, 1'b0);
    do_w(64'hBBBB, 8'h0C, 1'b0);
    do_w(64'hCCCC, 8'h30, 1'b0);
    @(negedge clk);
    check("R6", "no response without last", 128'(b_valid), 128'd0);
    peek(2'd2, 3'd2, h, r);
    check("R9", "slot 2 holds first beat", 128'({h, r}), 128'({1'b1, wrec(64'hAAAA, 8'h03, 1'b0)}));
    peek(2'd2, 3'd3, h, r);
    check("R9", "slot 3 beyond fill", 128'({h, r}), 128'd0);
    peek(2'd3, 3'd0, h, r);
    check("R9", "channel code 3", 128'({h, r}), 128'd0);
  endtask

  // R1/R5/R6: stalled write response
  task automatic t_write_resp();
    b_ready = 1'b0;
    do_aw(32'h40, 8'd0, 3'd3, 4'd5);
    @(negedge clk);
    w_data = 64'h55; w_strb = 8'hFF; w_last = 1'b1; w_valid = 1'b1;
    check("R6", "no response before last accepted", 128'(b_valid), 128'd0);
    @(posedge clk); #1;
    w_valid = 1'b0;
    check("R6", "response one cycle after last", 128'(b_valid), 128'd1);
    check("R6", "b_resp OKAY", 128'(b_resp), 128'd0);
    check("R6", "b_id from write address", 128'(b_id), 128'd5);
    check("R5", "w_ready low while pending", 128'({aw_ready, w_ready}), 128'd0);
    @(negedge clk);
    w_valid = 1'b1; w_data = 64'h77;
    repeat (2) @(negedge clk);
    check("R1", "beat not captured without ready", 128'(cnt_w), 128'd4);
    check("R6", "response held", 128'({b_valid, b_id}), 128'({1'b1, 4'd5}));
    w_valid = 1'b0; b_ready = 1'b1;
    @(negedge clk);
    check("R6", "response released", 128'(b_valid), 128'd0);
    check("R5", "ready after release", 128'({aw_ready, w_ready}), 128'h3);
  endtask

  // R1: payload moving with valid low
  task automatic t_valid_low();
    logic [3:0] c0;
    @(negedge clk);
    c0 = cnt_ar;
    for (int i = 0; i < 4; i++) begin
      ar_addr = 32'hF00 + 32'(i); ar_len = 8'(i); ar_id = 4'(i);
      @(negedge clk);
    end
    check("R1", "no capture with valid low", 128'(cnt_ar), 128'(c0));
  endtask

  // R7: four-beat read with a stall
  task automatic t_read_resp();
    r_ready = 1'b0;
    do_ar(32'h200, 8'd3, 3'd3, 4'd9);
    @(negedge clk);
    check("R7", "burst starts", 128'({r_valid, r_last, r_id}), 128'({1'b1, 1'b0, 4'd9}));
    check("R5", "ar_ready low during burst", 128'(ar_ready), 128'd0);
    @(negedge clk);
    check("R7", "r_valid held while stalled", 128'(r_valid), 128'd1);
    r_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R7", $sformatf("beat %0d", i), 128'({r_valid, r_last, r_resp, r_data}),
            128'({1'b1, (i == 3), 2'b00, FILL}));
      @(negedge clk);
    end
    check("R7", "burst done", 128'({r_valid, ar_ready}), 128'({1'b0, 1'b1}));
  endtask

  // R8: clear coincides with an accepted transfer
  task automatic t_clear();
    do_aw(32'h300, 8'd0, 3'd1, 4'd1);
    @(negedge clk);
    clear = 1'b1;
    aw_addr = 32'h301; aw_valid = 1'b1;
    check("R5", "aw_ready during clear", 128'(aw_ready), 128'd1);
    @(negedge clk);
    clear = 1'b0; aw_valid = 1'b0;
    check("R8", "all counts empty", 128'({cnt_ar, cnt_aw, cnt_w}), 128'd0);
    @(negedge clk);
    check("R8", "concurrent transfer dropped", 128'(cnt_aw), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rwr_sizes();
    t_wrap();
    t_partial();
    t_write_resp();
    t_valid_low();
    t_read_resp();
    t_clear();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule